// File: doc/BRIEF.md
# Weighted Correlation Score Combiner

This block turns the eight per-stage match counts of a binary correlation array into one score. Each stage count is scaled by a power-of-two weight chosen by the input data precision, so that stages holding higher bit planes of a multi-bit sample count for more. A programmable offset is added, and the result passes through an alignment delay of 1 to 16 clocks. It is then summed with a 13-bit cascade input. Several blocks can be chained, each one's cascade output feeding the next one's cascade input. The delays are set so that every score in the chain refers to the same sample.

In split mode the block yields two independent scores instead. The upper four stages with offset A form score A, which drives the low nine bits of the cascade output. The lower four stages with a 9-bit offset B form score B, which drives the auxiliary output. The cascade input is not used in this mode.

The block accepts a new set of counts on every clock and produces a result on every clock. It has no valid/ready handshake and no back-pressure: the pipeline always advances. The configuration pins are static levels sampled on every edge.

Top module: `corr_score_summer`

## Requirements
- R1: While the synchronous active-high reset is asserted, both `cas_out_o` and `aux_o` are zero, and every entry of the delay line is cleared to zero.
- R2: The stage count of stage s is read from `stage_cnt_i[6*s +: 6]`. In full mode (`split_i`=0), the weights for stages 7 down to 0 depend on `prec_i` as follows.
  - 0 (1-bit data): all 1.
  - 1 (2-bit data): 2,2,2,2,1,1,1,1.
  - 2 (4-bit data): 8,8,4,4,2,2,1,1.
  - 3 (8-bit data): 128,64,32,16,8,4,2,1.
- R3: In split mode (`split_i`=1), stages 7..4 and stages 3..0 are each weighted, from the high stage of the half down to the low stage, as follows.
  - `prec_i`=0: 1,1,1,1.
  - `prec_i`=1: 2,2,1,1.
  - `prec_i`=2 or 3: 8,4,2,1.
- R4: For delay code c on `dly_code_i` at edge n, the output after edge n is built from two parts. The weighted, offset score comes from the stage counts and configuration sampled at edge n-1-c. In full mode, the cascade input sampled at edge n is added to it. A code change therefore takes effect at the next edge. Two blocks chained with codes 0 and 1 produce aligned totals.
- R5: Offset A (13 bits) is added to the full-mode score and to split-mode score A. Offset B (9 bits) is added to score B. Both are added before the delay.
- R6: In split mode, `cas_out_o[12:9]` is zero, `cas_out_o[8:0]` is score A modulo 512, and `cas_in_i` has no effect.
- R7: In split mode `aux_o` carries score B modulo 512. In full mode `aux_o` is zero.
- R8: All full-mode sums wrap modulo 8192 without saturation.
- R9: With 8-bit precision, every stage count at 32 and zero offset and cascade input, the full-mode output is 8160.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| stage_cnt_i | input | 48 | Eight 6-bit stage counts, stage s at bits 6s+5..6s |
| prec_i | input | 2 | Data precision code: 0=1-bit, 1=2-bit, 2=4-bit, 3=8-bit |
| split_i | input | 1 | 1 = two independent scores, 0 = one full score |
| off_a_i | input | 13 | Offset for the full score or score A |
| off_b_i | input | 9 | Offset for score B |
| dly_code_i | input | 4 | Alignment delay code, c gives c+1 delay stages |
| cas_in_i | input | 13 | Cascade input from the previous block |
| cas_out_o | output | 13 | Cascade output or score A |
| aux_o | output | 9 | Score B in split mode, zero otherwise |

## Verification
The bench targets the weight tables at every precision in both modes. A swapped or off-by-one shift would make the weighted sum disagree with the model on random counts. It also aims at the delay tap around code changes and at the two-block chain. An extra or missing register there would misalign the cascade total by a cycle. Directed cases cover the 8160 maximum and a wrapping sum, which expose a saturating or too-narrow adder. In split mode the bench drives a large cascade input, which shows up on the output if that input leaks through.

// File: rtl/corr_sum_pkg.sv
package corr_sum_pkg;

  typedef enum logic [1:0] {
    PREC_1B = 2'd0,
    PREC_2B = 2'd1,
    PREC_4B = 2'd2,
    PREC_8B = 2'd3
  } prec_e;

  // Left-shift applied to a stage count: the weight is 1 << shift.
  function automatic int stage_shift(input logic [1:0] prec, input logic split,
                                     input int idx, input int n_stages);
    int half;
    int j;
    half = n_stages / 2;
    j    = idx % half;
    if (split) begin
      case (prec_e'(prec))
        PREC_1B: return 0;
        PREC_2B: return (j >= half / 2) ? 1 : 0;
        default: return j;
      endcase
    end else begin
      case (prec_e'(prec))
        PREC_1B: return 0;
        PREC_2B: return (idx >= half) ? 1 : 0;
        PREC_4B: return idx / 2;
        default: return idx;
      endcase
    end
  endfunction

endpackage

// File: rtl/score_weighter.sv
module score_weighter
  import corr_sum_pkg::*;
#(
  parameter int NUM_STAGES = 8,
  parameter int CNT_W      = 6,
  parameter int SCORE_W    = 13,
  parameter int AUX_W      = 9
) (
  input  logic [NUM_STAGES*CNT_W-1:0] cnt_i,
  input  logic [1:0]                  prec_i,
  input  logic                        split_i,
  input  logic [SCORE_W-1:0]          off_a_i,
  input  logic [AUX_W-1:0]            off_b_i,
  output logic [SCORE_W-1:0]          score_a_o,
  output logic [AUX_W-1:0]            score_b_o
);
  localparam int HALF = NUM_STAGES / 2;

  logic [SCORE_W-1:0] term [NUM_STAGES];
  logic [SCORE_W-1:0] sum_hi;
  logic [SCORE_W-1:0] sum_lo;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_term
    assign term[g] = SCORE_W'(cnt_i[g*CNT_W +: CNT_W])
                     << stage_shift(prec_i, split_i, g, NUM_STAGES);
  end

  always_comb begin
    sum_hi = '0;
    sum_lo = '0;
    for (int i = 0; i < NUM_STAGES; i++) begin
      if (i >= HALF) sum_hi = sum_hi + term[i];
      else           sum_lo = sum_lo + term[i];
    end
  end

  assign score_a_o = (split_i ? sum_hi : sum_hi + sum_lo) + off_a_i;
  assign score_b_o = sum_lo[AUX_W-1:0] + off_b_i;

endmodule

// File: rtl/score_delay.sv
module score_delay #(
  parameter int W     = 22,
  parameter int DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic [W-1:0]             din_i,
  input  logic [$clog2(DEPTH)-1:0] code_i,
  output logic [W-1:0]             tap_o
);
  logic [W-1:0] sr_q [DEPTH];
  logic [1:0]   fill_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
      fill_q <= '0;
    end else begin
      sr_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
      if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
    end
  end

  assign tap_o = sr_q[code_i];

  // R4: shortest and next tap hold the input of one and two edges back
  assert_tap_code0_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (fill_q != 2'd0 && code_i == '0) |-> tap_o == $past(din_i));
  assert_tap_code1_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (fill_q >= 2'd2 && code_i == 1) |-> tap_o == $past(din_i, 2));

endmodule

// File: rtl/corr_score_summer.sv
module corr_score_summer
  import corr_sum_pkg::*;
#(
  parameter int NUM_STAGES     = 8,
  parameter int TAPS_PER_STAGE = 32,
  parameter int SCORE_W        = 13,
  parameter int AUX_W          = 9,
  parameter int DLY_DEPTH      = 16
) (
  input  logic                                            clk_i,
  input  logic                                            rst_i,
  input  logic [NUM_STAGES*$clog2(TAPS_PER_STAGE+1)-1:0]  stage_cnt_i,
  input  logic [1:0]                                      prec_i,
  input  logic                                            split_i,
  input  logic [SCORE_W-1:0]                              off_a_i,
  input  logic [AUX_W-1:0]                                off_b_i,
  input  logic [$clog2(DLY_DEPTH)-1:0]                    dly_code_i,
  input  logic [SCORE_W-1:0]                              cas_in_i,
  output logic [SCORE_W-1:0]                              cas_out_o,
  output logic [AUX_W-1:0]                                aux_o
);
  localparam int CNT_W   = $clog2(TAPS_PER_STAGE + 1);
  localparam int ENTRY_W = SCORE_W + AUX_W;

  logic [SCORE_W-1:0] score_a;
  logic [AUX_W-1:0]   score_b;
  logic [ENTRY_W-1:0] tap;
  logic [SCORE_W-1:0] tap_a;
  logic [AUX_W-1:0]   tap_b;

  score_weighter #(
    .NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W), .SCORE_W(SCORE_W), .AUX_W(AUX_W)
  ) u_weighter (
    .cnt_i(stage_cnt_i), .prec_i(prec_i), .split_i(split_i),
    .off_a_i(off_a_i), .off_b_i(off_b_i),
    .score_a_o(score_a), .score_b_o(score_b)
  );

  score_delay #(.W(ENTRY_W), .DEPTH(DLY_DEPTH)) u_delay (
    .clk_i(clk_i), .rst_i(rst_i), .din_i({score_b, score_a}),
    .code_i(dly_code_i), .tap_o(tap)
  );

  assign tap_a = tap[SCORE_W-1:0];
  assign tap_b = tap[ENTRY_W-1:SCORE_W];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cas_out_o <= '0;
      aux_o     <= '0;
    end else if (split_i) begin
      cas_out_o <= {{(SCORE_W-AUX_W){1'b0}}, tap_a[AUX_W-1:0]};
      aux_o     <= tap_b;
    end else begin
      cas_out_o <= tap_a + cas_in_i;
      aux_o     <= '0;
    end
  end

  // R6: split mode leaves the upper cascade bits clear
  assert_split_high_clear_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(split_i) |-> cas_out_o[SCORE_W-1:AUX_W] == '0);
  // R7: auxiliary output idle in full mode
  assert_aux_quiet_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(split_i) |-> aux_o == '0);

endmodule

// File: tb/corr_score_summer_tb.sv
`timescale 1ns/1ps
module corr_score_summer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] cnt = '0, cnt2 = '0;
  logic [1:0]  prec = '0;
  logic        split = 1'b0;
  logic [12:0] offa = '0, cin = '0;
  logic [8:0]  offb = '0;
  logic [3:0]  code = '0;
  logic [12:0] cas1, cas2;
  logic [8:0]  aux1, aux2;

  int checks = 0, errors = 0;
  int n = -1, post = 0, prev_cas1 = 0;
  int wa_h[32], wb_h[32], cin_h[32], code_h[32], w2_h[32];
  bit split_h[32];

  always #10 clk = ~clk;

  corr_score_summer u_dut (
    .clk_i(clk), .rst_i(rst), .stage_cnt_i(cnt), .prec_i(prec), .split_i(split),
    .off_a_i(offa), .off_b_i(offb), .dly_code_i(code), .cas_in_i(cin),
    .cas_out_o(cas1), .aux_o(aux1));

  // second block of a chain: cascade input fed from u_dut, delay code 1
  corr_score_summer u_dut2 (
    .clk_i(clk), .rst_i(rst), .stage_cnt_i(cnt2), .prec_i(2'd3), .split_i(1'b0),
    .off_a_i(13'd5), .off_b_i(9'd0), .dly_code_i(4'd1), .cas_in_i(cas1),
    .cas_out_o(cas2), .aux_o(aux2));

  function automatic int wt(input int p, input bit sp, input int s);
    int j;
    j = s % 4;
    if (!sp) begin
      case (p)
        0: return 1;
        1: return (s >= 4) ? 2 : 1;
        2: return (s >= 6) ? 8 : (s >= 4) ? 4 : (s >= 2) ? 2 : 1;
        default: return 1 << s;
      endcase
    end
    case (p)
      0: return 1;
      1: return (j >= 2) ? 2 : 1;
      default: return 1 << j;
    endcase
  endfunction

  function automatic int model_a(input logic [47:0] c, input int p, input bit sp, input int off);
    int acc = off;
    for (int s = 0; s < 8; s++)
      if (!sp || s >= 4) acc += wt(p, sp, s) * int'(c[s*6 +: 6]);
    return acc % 8192;
  endfunction

  function automatic int model_b(input logic [47:0] c, input int p, input bit sp, input int off);
    int acc = off;
    for (int s = 0; s < 4; s++) acc += wt(p, sp, s) * int'(c[s*6 +: 6]);
    return acc % 512;
  endfunction

  always @(posedge clk) begin
    int k;
    n++;
    k = n % 32;
    code_h[k] = int'(code);
    split_h[k] = split;
    cin_h[k] = int'(cin);
    if (rst) begin
      wa_h[k] = 0; wb_h[k] = 0; w2_h[k] = 0; post = 0;
    end else begin
      wa_h[k] = model_a(cnt, int'(prec), split, int'(offa));
      wb_h[k] = model_b(cnt, int'(prec), split, int'(offb));
      w2_h[k] = model_a(cnt2, 3, 1'b0, 5);
      post++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_check();
    int k, idx, ea, eb;
    k = n % 32;
    idx = n - 1 - code_h[k];
    ea = (idx < 0) ? 0 : wa_h[idx % 32];
    eb = (idx < 0) ? 0 : wb_h[idx % 32];
    if (split_h[k]) begin
      chk("R3 R6 split cas_out", int'(cas1), ea % 512);
      chk("R3 R5 R7 split aux", int'(aux1), eb);
    end else begin
      chk("R2 R4 R5 full cas_out", int'(cas1), (ea + cin_h[k]) % 8192);
      chk("R7 full aux", int'(aux1), 0);
    end
    if (post >= 3)
      chk("R4 chain aligned total", int'(cas2), (w2_h[(n - 2) % 32] + prev_cas1) % 8192);
  endtask

  task automatic step();
    @(negedge clk);
    if (!rst) model_check();
    prev_cas1 = int'(cas1);
  endtask

  task automatic fill(input int v);
    for (int s = 0; s < 8; s++) cnt[s*6 +: 6] = 6'(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", n, 200000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) step();
    chk("R1 reset cas_out", int'(cas1), 0);
    chk("R1 reset aux", int'(aux1), 0);
    rst = 1'b0;

    // R9: largest 8-bit score
    prec = 2'd3; fill(32);
    repeat (3) step();
    chk("R9 max 8-bit score", int'(cas1), 8160);

    // R8: wrap modulo 8192
    offa = 13'd8191; cin = 13'd100;
    repeat (3) step();
    chk("R8 wrapped sum", int'(cas1), 67);

    // R6 / R7: split mode ignores cascade input
    split = 1'b1; prec = 2'd2; offa = '0; offb = '0; cin = 13'd8191;
    for (int s = 0; s < 4; s++) cnt[s*6 +: 6] = 6'd1;
    for (int s = 4; s < 8; s++) cnt[s*6 +: 6] = 6'd32;
    repeat (3) step();
    chk("R6 split ignores cas_in", int'(cas1), 480);
    chk("R7 split aux score", int'(aux1), 15);

    // random mix, every cycle checked against the model
    split = 1'b0; offa = '0; cin = '0;
    for (int i = 0; i < 1500; i++) begin
      for (int s = 0; s < 8; s++) begin
        cnt[s*6 +: 6]  = 6'($urandom_range(32));
        cnt2[s*6 +: 6] = 6'($urandom_range(32));
      end
      prec  = 2'($urandom_range(3));
      split = ($urandom_range(3) == 0);
      offa  = 13'($urandom);
      offb  = 9'($urandom);
      cin   = 13'($urandom);
      if ($urandom_range(19) == 0) code = 4'($urandom_range(15));
      if (i == 1000) code = 4'd15;
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule